// File: doc/BRIEF.md
# Indirect Banked Register Bridge

This block sits on the management side of a PHY-style device. A host drives a plain parallel register port (address, write strobe, read strobe, 16-bit data) that reaches 32 directly addressed 16-bit registers. Three of these registers are reserved: a command register, a read-capture register and a write-staging register. Through them the host reaches up to eight register banks, each addressed by an 8-bit offset.

Bank code 0 aliases the direct register space. Codes 1 to 4 select internal register files (miscellaneous, coding sublayer, analog front end, DSP), and codes 5 to 7 are unimplemented. To write, the host stages a value and then issues a write command. To read, it issues a read command and reads the capture register on the next bus cycle. A malformed command raises a sticky error flag. Direct register 0 carries a self-clearing soft-reset bit.

Top module: `brg_indirect_bridge`

## Requirements
- R1: After reset, every direct register, every bank entry and the capture register read 0x0000, and `cmd_err_o` is 0.
- R2: A host write stores `wdata_i` at `addr_i` for every direct address except 0x15. `rdata_o` shows the addressed register combinationally while `rd_i` is high, and shows 0x0000 while `rd_i` is low.
- R3: A write to address 0x14 stores the command word, which reads back unchanged. In that word, bit 12 is the read command, bit 11 is the write command, bits 10:8 are the bank code and bits 7:0 are the offset.
- R4: A write command commits the value held in address 0x16 before that clock edge to the selected bank and offset.
- R5: A read command captures the selected bank entry at its own clock edge, so a read of address 0x15 in the following cycle returns that entry.
- R6: Address 0x15 ignores host writes and keeps its value until the next valid read command.
- R7: A command word with both bits 12 and 11 set, or with neither set, accesses nothing and sets `cmd_err_o`. `cmd_err_o` stays set until reset.
- R8: Bank 0 maps offsets 0..31 onto the direct registers. Through bank 0, writes to offsets 0x14 and 0x15 are ignored. Offsets of 32 and above read 0x0000 and ignore writes.
- R9: Bank codes 5..7 read 0x0000 and ignore writes. In banks 1..4, offsets at or above BANK_DEPTH (default 64) read 0x0000 and ignore writes.
- R10: Writing 1 to bit 15 of register 0, directly or through bank 0, makes that bit read 1 for exactly RST_HOLD cycles (default 8) and then 0. Bits 14:0 of register 0 behave as ordinary storage.
- R11: Banks 1..4 are independent: the same offset in different banks holds distinct values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 5 | Direct register address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data (0 when rd_i is low) |
| cmd_err_o | output | 1 | Sticky malformed-command flag |

## Verification
The assertions assume that the host presents at most one write per cycle. They also assume that an address and its strobes stay stable through the clock edge that samples them. The bench therefore drives every input on the falling edge and holds it for a full period. The reserved addresses are reached only through ordinary bus writes, so indirect and direct writes to the same register never coincide; the address comparison on the bank-0 path rules out the only overlap. The random phase issues well-formed commands only, so the sticky error flag is exercised last and does not mask the comparisons made earlier.

// File: rtl/brg_pkg.sv
package brg_pkg;
  localparam int DW        = 16;
  localparam int CTRL_OFS  = 20;  // 0x14
  localparam int RDCAP_OFS = 21;  // 0x15
  localparam int STAGE_OFS = 22;  // 0x16
  localparam int RD_BIT    = 12;
  localparam int WR_BIT    = 11;
  localparam int BANK_LSB  = 8;
  localparam int BANK_W    = 3;
  localparam int OFF_W     = 8;
  localparam int NUM_CODES = 1 << BANK_W;
endpackage

// File: rtl/brg_cmd_dec.sv
module brg_cmd_dec
  import brg_pkg::*;
(
  input  logic              valid_i,
  input  logic [DW-1:0]     word_i,
  output logic              acc_rd_o,
  output logic              acc_wr_o,
  output logic              bad_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [OFF_W-1:0]  off_o
);
  logic rd_b, wr_b;
  logic unused_w;

  assign rd_b     = word_i[RD_BIT];
  assign wr_b     = word_i[WR_BIT];
  assign acc_rd_o = valid_i & rd_b & ~wr_b;
  assign acc_wr_o = valid_i & wr_b & ~rd_b;
  assign bad_o    = valid_i & ~(rd_b ^ wr_b);
  assign bank_o   = word_i[BANK_LSB +: BANK_W];
  assign off_o    = word_i[OFF_W-1:0];
  assign unused_w = ^word_i[DW-1:RD_BIT+1];
endmodule

// File: rtl/brg_bank.sv
module brg_bank
  import brg_pkg::*;
#(
  parameter int DEPTH = 64   // power of two, <= 256
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [OFF_W-1:0] woff_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [OFF_W-1:0] roff_i,
  output logic [DW-1:0]    rdata_o
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] mem_q [DEPTH];
  logic w_hit, r_hit;
  logic [IDX_W-1:0] widx, ridx;

  assign w_hit = int'(woff_i) < DEPTH;
  assign r_hit = int'(roff_i) < DEPTH;
  assign widx  = woff_i[IDX_W-1:0];
  assign ridx  = roff_i[IDX_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i && w_hit) begin
      mem_q[widx] <= wdata_i;
    end
  end

  assign rdata_o = r_hit ? mem_q[ridx] : '0;

  // R9: out-of-range offsets never return stored data
  a_r9_oob_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !r_hit |-> rdata_o == '0);
endmodule

// File: rtl/brg_direct_regs.sv
module brg_direct_regs
  import brg_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int RST_HOLD = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              h_we_i,
  input  logic [ADDR_W-1:0] h_addr_i,
  input  logic [DW-1:0]     h_wdata_i,
  input  logic              i_we_i,
  input  logic [ADDR_W-1:0] i_addr_i,
  input  logic [DW-1:0]     i_wdata_i,
  input  logic [DW-1:0]     rdcap_i,
  input  logic [ADDR_W-1:0] h_raddr_i,
  output logic [DW-1:0]     h_rdata_o,
  input  logic [ADDR_W-1:0] i_raddr_i,
  output logic [DW-1:0]     i_rdata_o,
  output logic [DW-1:0]     stage_o
);
  localparam int NREG  = 1 << ADDR_W;
  localparam int CNT_W = $clog2(RST_HOLD + 1);
  localparam logic [CNT_W-1:0] HOLD_V = CNT_W'(RST_HOLD);

  logic [DW-1:0]    view [NREG];
  logic [CNT_W-1:0] cnt_q;
  logic             srst_start, srst_busy;

  assign srst_start = (h_we_i && h_addr_i == '0 && h_wdata_i[DW-1]) ||
                      (i_we_i && i_addr_i == '0 && i_wdata_i[DW-1]);
  assign srst_busy  = cnt_q != '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (srst_start)      cnt_q <= HOLD_V;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g == RDCAP_OFS) begin : g_cap
      assign view[g] = rdcap_i;
    end else if (g == 0) begin : g_ctl0
      logic [DW-2:0] low_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                 low_q <= '0;
        else if (h_we_i && h_addr_i == ADDR_W'(g))   low_q <= h_wdata_i[DW-2:0];
        else if (i_we_i && i_addr_i == ADDR_W'(g))   low_q <= i_wdata_i[DW-2:0];
      end
      assign view[g] = {srst_busy, low_q};
    end else begin : g_plain
      logic [DW-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                 q <= '0;
        else if (h_we_i && h_addr_i == ADDR_W'(g))   q <= h_wdata_i;
        else if (i_we_i && i_addr_i == ADDR_W'(g))   q <= i_wdata_i;
      end
      assign view[g] = q;
    end
  end

  assign h_rdata_o = view[h_raddr_i];
  assign i_rdata_o = view[i_raddr_i];
  assign stage_o   = view[STAGE_OFS];

  // R10: soft-reset bit visible right after being set
  a_r10_srst_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_start |=> view[0][DW-1]);
  // R10: bit self-clears when the hold window ends
  a_r10_srst_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_W'(1) && !srst_start) |=> !view[0][DW-1]);
endmodule

// File: rtl/brg_indirect_bridge.sv
module brg_indirect_bridge
  import brg_pkg::*;
#(
  parameter int ADDR_W        = 5,
  parameter int NUM_INT_BANKS = 4,
  parameter int BANK_DEPTH    = 64,
  parameter int RST_HOLD      = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic              cmd_err_o
);
  localparam int NREG = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] CTRL_A  = ADDR_W'(CTRL_OFS);
  localparam logic [ADDR_W-1:0] RDCAP_A = ADDR_W'(RDCAP_OFS);

  logic              ctrl_wr, acc_rd, acc_wr, bad;
  logic [BANK_W-1:0] bank;
  logic [OFF_W-1:0]  off;
  logic [DW-1:0]     rdcap_q, stage, h_rdata, d_irdata;
  logic              err_q, b0_hit, b0_we;
  logic [DW-1:0]     bank_rd [NUM_CODES];

  assign ctrl_wr = wr_i && addr_i == CTRL_A;

  brg_cmd_dec i_dec (
    .valid_i (ctrl_wr),
    .word_i  (wdata_i),
    .acc_rd_o(acc_rd),
    .acc_wr_o(acc_wr),
    .bad_o   (bad),
    .bank_o  (bank),
    .off_o   (off)
  );

  // bank 0 aliases the direct space; command/capture slots are not indirect targets
  assign b0_hit = int'(off) < NREG;
  assign b0_we  = acc_wr && bank == '0 && b0_hit &&
                  off[ADDR_W-1:0] != CTRL_A && off[ADDR_W-1:0] != RDCAP_A;

  brg_direct_regs #(.ADDR_W(ADDR_W), .RST_HOLD(RST_HOLD)) i_dir (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .h_we_i   (wr_i),
    .h_addr_i (addr_i),
    .h_wdata_i(wdata_i),
    .i_we_i   (b0_we),
    .i_addr_i (off[ADDR_W-1:0]),
    .i_wdata_i(stage),
    .rdcap_i  (rdcap_q),
    .h_raddr_i(addr_i),
    .h_rdata_o(h_rdata),
    .i_raddr_i(off[ADDR_W-1:0]),
    .i_rdata_o(d_irdata),
    .stage_o  (stage)
  );

  for (genvar b = 0; b < NUM_CODES; b++) begin : g_bank
    if (b == 0) begin : g_alias
      assign bank_rd[b] = b0_hit ? d_irdata : '0;
    end else if (b <= NUM_INT_BANKS) begin : g_file
      brg_bank #(.DEPTH(BANK_DEPTH)) i_bank (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .we_i   (acc_wr && bank == BANK_W'(b)),
        .woff_i (off),
        .wdata_i(stage),
        .roff_i (off),
        .rdata_o(bank_rd[b])
      );
    end else begin : g_none
      assign bank_rd[b] = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdcap_q <= '0;
    else if (acc_rd)  rdcap_q <= bank_rd[bank];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   err_q <= 1'b0;
    else if (bad)  err_q <= 1'b1;
  end

  assign cmd_err_o = err_q;
  assign rdata_o   = rd_i ? h_rdata : '0;

  // R7: malformed command raises the flag
  a_r7_err_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == CTRL_A && wdata_i[RD_BIT] == wdata_i[WR_BIT]) |=> cmd_err_o);
  // R7: flag is sticky
  a_r7_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_err_o |=> cmd_err_o);
  // R6: capture holds without a valid read command
  a_r6_cap_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && addr_i == CTRL_A && wdata_i[RD_BIT] && !wdata_i[WR_BIT]) |=> $stable(rdcap_q));
  // R9: unimplemented bank codes capture zero
  a_r9_unimpl_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == CTRL_A && wdata_i[RD_BIT] && !wdata_i[WR_BIT] &&
     int'(wdata_i[BANK_LSB +: BANK_W]) > NUM_INT_BANKS) |=> rdcap_q == '0);
  // R5: host read of the capture slot returns the captured word
  a_r5_cap_visible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == RDCAP_A) |-> rdata_o == rdcap_q);
endmodule

// File: tb/test_brg_indirect_bridge.sv
module test_brg_indirect_bridge;
  localparam int H    = 8;
  localparam int DEP  = 64;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  addr_i = '0;
  logic        wr_i = 1'b0, rd_i = 1'b0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        cmd_err_o;

  always #4 clk_i = ~clk_i;  // 125 MHz

  brg_indirect_bridge i_brg_indirect_bridge (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_i(wr_i), .rd_i(rd_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .cmd_err_o(cmd_err_o)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // behavioural reference
  logic [15:0] m_dir [32];
  logic [15:0] m_bank [1:4][DEP];
  logic [15:0] m_cap;
  bit          m_err;
  int          m_cnt;

  function automatic logic [15:0] m_read(int a);
    if (a == 0)  return {m_cnt != 0, m_dir[0][14:0]};
    if (a == 21) return m_cap;
    return m_dir[a];
  endfunction

  function automatic logic [15:0] m_iread(int b, int o);
    if (b == 0) return (o < 32) ? m_read(o) : 16'h0;
    if (b <= 4) return (o < DEP) ? m_bank[b][o] : 16'h0;
    return 16'h0;
  endfunction

  task automatic m_dwrite(int a, logic [15:0] d);
    if (a == 21) return;
    if (a == 0) begin
      m_dir[0] = d & 16'h7fff;
      if (d[15]) m_cnt = H;
    end else m_dir[a] = d;
  endtask

  task automatic m_iwrite(int b, int o, logic [15:0] d);
    if (b == 0) begin
      if (o < 32 && o != 20 && o != 21) m_dwrite(o, d);
    end else if (b <= 4 && o < DEP) m_bank[b][o] = d;
  endtask

  task automatic m_step(int a, bit w, logic [15:0] d);
    bit is_cmd, crd, cwr;
    int cb, co;
    logic [15:0] rv, stg;
    is_cmd = w && a == 20;
    crd = d[12]; cwr = d[11]; cb = int'(d[10:8]); co = int'(d[7:0]);
    rv  = m_iread(cb, co);
    stg = m_dir[22];
    if (m_cnt > 0) m_cnt--;
    if (w) m_dwrite(a, d);
    if (is_cmd) begin
      if (crd == cwr) m_err = 1;
      else if (cwr)   m_iwrite(cb, co, stg);
      else            m_cap = rv;
    end
  endtask

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(int a, bit w, bit r, logic [15:0] d, string tag);
    @(negedge clk_i);
    addr_i = 5'(a); wr_i = w; rd_i = r; wdata_i = d;
    #2;
    check({tag, " rdata"}, rdata_o, r ? m_read(a) : 16'h0);
    check("R7 err", {15'b0, cmd_err_o}, {15'b0, m_err});
    @(posedge clk_i);
    m_step(a, w, d);
  endtask

  task automatic rd(int a, string tag);
    cyc(a, 0, 1, 16'h0, tag);
  endtask

  task automatic wr(int a, logic [15:0] d, string tag);
    cyc(a, 1, 0, d, tag);
  endtask

  function automatic logic [15:0] cw(bit r, bit w, int b, int o);
    return {3'b0, r, w, 3'(b), 8'(o)};
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : main
    for (int i = 0; i < 32; i++) m_dir[i] = '0;
    for (int b = 1; b <= 4; b++) for (int i = 0; i < DEP; i++) m_bank[b][i] = '0;
    m_cap = '0; m_err = 0; m_cnt = 0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;

    // R1 reset state
    rd(0, "R1"); rd(20, "R1"); rd(21, "R1"); rd(22, "R1"); rd(5, "R1");
    wr(20, cw(1, 0, 3, 7), "R1"); rd(21, "R1 bank3");

    // R2 direct storage, idle rdata
    wr(3, 16'ha5a5, "R2"); wr(31, 16'h5a5a, "R2");
    rd(3, "R2"); rd(31, "R2"); cyc(3, 0, 0, 16'h0, "R2 idle");

    // R3 command word readback
    wr(20, cw(1, 0, 2, 9), "R3"); rd(20, "R3");

    // R6 capture is read-only
    wr(22, 16'hbeef, "R6"); wr(20, cw(1, 0, 0, 22), "R6"); wr(21, 16'h1111, "R6"); rd(21, "R6");

    // R4 / R5 indirect write and read-back
    wr(22, 16'h1234, "R4"); wr(20, cw(0, 1, 1, 11), "R4");
    wr(20, cw(1, 0, 1, 11), "R5"); rd(21, "R5");

    // R11 independent banks
    wr(22, 16'h4321, "R11"); wr(20, cw(0, 1, 2, 11), "R11");
    wr(20, cw(1, 0, 1, 11), "R11"); rd(21, "R11 b1");
    wr(20, cw(1, 0, 2, 11), "R11"); rd(21, "R11 b2");

    // R9 unimplemented banks and out-of-range offsets
    wr(22, 16'h7777, "R9"); wr(20, cw(0, 1, 5, 3), "R9");
    wr(20, cw(1, 0, 5, 3), "R9"); rd(21, "R9 bank5");
    wr(20, cw(0, 1, 4, 64), "R9"); wr(20, cw(1, 0, 4, 64), "R9"); rd(21, "R9 oob");
    wr(20, cw(0, 1, 4, 63), "R9"); wr(20, cw(1, 0, 4, 63), "R9"); rd(21, "R9 last");

    // R8 bank 0 alias
    wr(22, 16'h0c0c, "R8"); wr(20, cw(0, 1, 0, 3), "R8"); rd(3, "R8");
    wr(20, cw(0, 1, 0, 21), "R8"); rd(21, "R8 cap");
    wr(20, cw(0, 1, 0, 20), "R8"); rd(20, "R8 ctl");
    wr(20, cw(1, 0, 0, 64), "R8"); rd(21, "R8 hi");
    wr(20, cw(1, 0, 0, 31), "R8"); rd(21, "R8 alias");

    // R10 soft reset, direct then through bank 0
    wr(0, 16'h8005, "R10");
    for (int i = 0; i < H + 3; i++) rd(0, "R10");
    wr(22, 16'h8002, "R10"); wr(20, cw(0, 1, 0, 0), "R10");
    for (int i = 0; i < H + 3; i++) rd(0, "R10 ind");

    // random well-formed traffic
    for (int k = 0; k < 800; k++) begin
      int op = $urandom_range(0, 5);
      int a  = $urandom_range(0, 31);
      bit r  = 1'($urandom_range(0, 1));
      if (a == 20) a = 22;
      case (op)
        0: cyc(a, 1, r, 16'($urandom), "R2 rnd");
        1: cyc(20, 1, r, cw(0, 1, $urandom_range(0, 7), $urandom_range(0, 80)), "R4 rnd");
        2: cyc(20, 1, r, cw(1, 0, $urandom_range(0, 7), $urandom_range(0, 80)), "R5 rnd");
        3: rd(21, "R5 rnd");
        default: cyc(a, 0, r, 16'h0, "R11 rnd");
      endcase
    end

    // R7 malformed commands, sticky flag
    wr(20, cw(1, 1, 1, 2), "R7 both"); rd(21, "R7");
    wr(20, cw(0, 0, 1, 2), "R7 none"); rd(21, "R7");
    for (int i = 0; i < 4; i++) rd(20, "R7 sticky");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule